// File: doc/BRIEF.md
# Space-Character Autobaud Detector

This block watches an asynchronous serial receive line whose baud rate is unknown. It times every stretch of constant line level in clock cycles. It also looks for the run-length signature that one ASCII space (0x20) produces when it is sent least-significant bit first with a start bit and a stop bit. On the line that signature is a long low of six bit-times, a short high of one bit-time, then a low of two bit-times, and then the line returns high.

The block checks the ratios between these runs against a tolerance window that scales with the long low run. When they fit, it derives the bit period from the two low runs and presents it in fixed point. In the same cycle it pulses a restart for a companion byte receiver, so that the receiver reloads with the new period and picks up the next frame. One cycle later it pushes a 0x20 byte toward the receive buffer, because the space that caused the lock may never reach the receiver.

Top module: `spc_autobaud`

## Requirements
- R1: While reset is held, and after it until a detection, `detect_o`, `rx_restart_o` and `inject_valid_o` are 0, `inject_data_o` is 0x00 and `bit_period_o` is 0.
- R2: `rx_async` passes through a two-stage synchroniser. `detect_o` pulses for exactly one cycle, in the third rising clock edge after `rx_async` goes high at the end of a matching pattern.
- R3: The block detects a low run of L0 cycles, then a high run of M cycles, then a low run of N cycles, when the ratio tests pass. On detection, `bit_period_o` becomes (L0+N)·2^(FRAC_W−3), which is (L0+N)/8 with FRAC_W fractional bits.
- R4: The window is [L0 − floor(L0/16), L0 + floor(L0/16)], bounds included. 6·M must lie inside it.
- R5: 3·N must lie inside the same window. When either test fails, no detection happens.
- R6: A run that ends with the line high only shifts the run history and never causes a detection.
- R7: `rx_restart_o` pulses in exactly the cycles in which `detect_o` pulses.
- R8: `inject_valid_o` pulses one cycle after each detection, with `inject_data_o` = 0x20. In every other cycle `inject_data_o` is 0x00.
- R9: `bit_period_o` keeps its value in every cycle that is not a detection cycle, and through patterns that do not match.
- R10: Run-length counters saturate at 2^CNT_W−1. A longer run is measured as 2^CNT_W−1 and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_async | input | 1 | Serial receive line, not yet synchronised; idle high |
| bit_period_o | output | CNT_W+FRAC_W−2 | Derived bit period in clock cycles, FRAC_W fractional bits |
| detect_o | output | 1 | One-cycle strobe when a space is recognised |
| rx_restart_o | output | 1 | One-cycle restart for the companion receiver |
| inject_valid_o | output | 1 | One-cycle strobe to write a byte into the receive buffer |
| inject_data_o | output | 8 | Injected byte: 0x20 while the strobe is high, else 0x00 |

## Verification
The assertions check four things on every cycle: the counter holds at saturation, a high-ended run never produces a strobe, the detect strobe lasts one cycle, and the inject strobe follows a restart while the period register holds between detections. Only the bench's scenarios show the pass/fail boundary of the tolerance window and the exact period value. The same applies to the synchroniser latency and to the recovery of a saturated long run. The bench sweeps the middle and newest runs across both window edges for several long-run lengths and computes the expected window arithmetically.

// File: rtl/spc_ab_pkg.sv
package spc_ab_pkg;
   localparam logic [7:0] SPACE_CODE = 8'h20;
   localparam int MID_SCALE = 6;   // one-bit high run scaled to six bits
   localparam int NEW_SCALE = 3;   // two-bit low run scaled to six bits
   localparam int WIN_SHIFT = 4;   // window half-width = long run / 16
   localparam int SUM_SHIFT = 3;   // eight bit-times in the two low runs
endpackage

// File: rtl/spc_ab_sync.sv
module spc_ab_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("spc_ab_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sh;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh[0] <= 1'b1;
            else        sh[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh[i] <= 1'b1;
            else        sh[i] <= sh[i-1];
         end
      end
   end

   assign q = sh[STAGES-1];
endmodule

// File: rtl/spc_ab_runlen.sv
module spc_ab_runlen #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx,
   output logic             run_done,
   output logic [CNT_W-1:0] run_len,
   output logic             run_lvl
);
   if (CNT_W < 4) begin : g_bad_width
      $error("spc_ab_runlen: CNT_W must be at least 4");
   end

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic             lvl_q;
   logic [CNT_W-1:0] cnt_q;

   assign run_done = (rx != lvl_q);
   assign run_len  = cnt_q;
   assign run_lvl  = lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q <= 1'b1;
         cnt_q <= '0;
      end else if (run_done) begin
         lvl_q <= rx;
         cnt_q <= CNT_W'(1);
      end else if (cnt_q != CNT_MAX) begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_done && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX)); // R10
endmodule

// File: rtl/spc_ab_match.sv
module spc_ab_match
   import spc_ab_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int FRAC_W = 16,
   localparam int PER_W = CNT_W + FRAC_W - SUM_SHIFT + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_done,
   input  logic [CNT_W-1:0] run_len,
   input  logic             run_lvl,
   output logic             det,
   output logic [PER_W-1:0] period
);
   if (FRAC_W < SUM_SHIFT) begin : g_bad_frac
      $error("spc_ab_match: FRAC_W must be at least 3");
   end

   localparam int XW = CNT_W + 3;

   // history: oldest and middle run held here, newest arrives on run_len
   logic [CNT_W-1:0] h_old, h_mid;
   logic [XW-1:0]    old_x, half, win_lo, win_hi, mid_sc, new_sc;
   logic             mid_ok, new_ok, hit;
   logic [CNT_W:0]   low_sum;
   logic [PER_W-1:0] per_next;
   logic             det_q;
   logic [PER_W-1:0] per_q;

   always_comb begin
      old_x  = XW'(h_old);
      half   = old_x >> WIN_SHIFT;
      win_lo = old_x - half;
      win_hi = old_x + half;
      mid_sc = XW'(h_mid) * XW'(MID_SCALE);
      new_sc = XW'(run_len) * XW'(NEW_SCALE);
      mid_ok = (mid_sc >= win_lo) && (mid_sc <= win_hi);
      new_ok = (new_sc >= win_lo) && (new_sc <= win_hi);
      hit    = run_done && !run_lvl && mid_ok && new_ok;
      low_sum = {1'b0, h_old} + {1'b0, run_len};
   end

   if (FRAC_W > SUM_SHIFT) begin : g_frac_pad
      assign per_next = {low_sum, {(FRAC_W-SUM_SHIFT){1'b0}}};
   end else begin : g_frac_none
      assign per_next = low_sum;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h_old <= '0;
         h_mid <= '0;
         det_q <= 1'b0;
         per_q <= '0;
      end else begin
         if (run_done) begin
            h_old <= h_mid;
            h_mid <= run_len;
         end
         det_q <= hit;
         if (hit) per_q <= per_next;
      end
   end

   assign det    = det_q;
   assign period = per_q;

   AST_HIGH_RUN_NO_DET: assert property (@(posedge clk) disable iff (!rst_n)
      (run_done && run_lvl) |=> !det_q); // R6
   AST_DET_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      det_q |=> !det_q); // R2
endmodule

// File: rtl/spc_autobaud.sv
module spc_autobaud
   import spc_ab_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int FRAC_W      = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        rx_async,
   output logic [CNT_W+FRAC_W-3:0]     bit_period_o,
   output logic                        detect_o,
   output logic                        rx_restart_o,
   output logic                        inject_valid_o,
   output logic [7:0]                  inject_data_o
);
   localparam int PER_W = CNT_W + FRAC_W - SUM_SHIFT + 1;

   logic             rx_s;
   logic             run_done, run_lvl;
   logic [CNT_W-1:0] run_len;
   logic             det;
   logic [PER_W-1:0] period;
   logic             inj_q;

   spc_ab_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(rx_async), .q(rx_s)
   );

   spc_ab_runlen #(.CNT_W(CNT_W)) u_runlen (
      .clk(clk), .rst_n(rst_n), .rx(rx_s),
      .run_done(run_done), .run_len(run_len), .run_lvl(run_lvl)
   );

   spc_ab_match #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_match (
      .clk(clk), .rst_n(rst_n), .run_done(run_done), .run_len(run_len),
      .run_lvl(run_lvl), .det(det), .period(period)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) inj_q <= 1'b0;
      else        inj_q <= det;
   end

   assign bit_period_o   = period;
   assign detect_o       = det;
   assign rx_restart_o   = det;
   assign inject_valid_o = inj_q;
   assign inject_data_o  = inj_q ? SPACE_CODE : 8'h00;

   AST_INJECT_AFTER_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      inject_valid_o |-> $past(rx_restart_o)); // R8
   AST_PERIOD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !detect_o |-> $stable(bit_period_o)); // R9
endmodule

// File: tb/spc_autobaud_tb.sv
`timescale 1ns/1ps
module spc_autobaud_tb;
   localparam int CW = 8;
   localparam int FW = 16;
   localparam int CMAX = (1 << CW) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rx_async = 1'b1;
   logic [CW+FW-3:0] bit_period_o;
   logic detect_o, rx_restart_o, inject_valid_o;
   logic [7:0] inject_data_o;

   int checks = 0, errors = 0;
   int cyc = 0, det_n = 0, det_cyc = 0, inj_cyc = 0, bad_rs = 0, bad_dat = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   spc_autobaud #(.CNT_W(CW), .FRAC_W(FW), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .rx_async(rx_async),
      .bit_period_o(bit_period_o), .detect_o(detect_o),
      .rx_restart_o(rx_restart_o), .inject_valid_o(inject_valid_o),
      .inject_data_o(inject_data_o)
   );

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (rst_n) begin
         if (detect_o) begin det_n = det_n + 1; det_cyc = cyc; end
         if (inject_valid_o) inj_cyc = cyc;
         if (rx_restart_o != detect_o) bad_rs = bad_rs + 1;
         if (inject_data_o != (inject_valid_o ? 8'h20 : 8'h00)) bad_dat = bad_dat + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      rx_async = 1'b1;
      repeat (n) @(negedge clk);
   endtask

   // low l0, high m, low n, then high; outcome computed from the window rule
   task automatic trial(input int l0, input int m, input int n, input string req);
      int le, h, d0, rise;
      longint p0, exp_per;
      bit hit;
      d0 = det_n;
      p0 = bit_period_o;
      rx_async = 1'b0; repeat (l0) @(negedge clk);
      rx_async = 1'b1; repeat (m)  @(negedge clk);
      rx_async = 1'b0; repeat (n)  @(negedge clk);
      rx_async = 1'b1; rise = cyc;
      repeat (200) @(negedge clk);
      le = (l0 > CMAX) ? CMAX : l0;
      h = le >> 4;
      hit = (6*m >= le-h) && (6*m <= le+h) && (3*n >= le-h) && (3*n <= le+h);
      exp_per = longint'(le + n) << (FW - 3);
      if (hit) begin
         chk(det_n == d0 + 1, {req, " detect count"}, det_n - d0, 1);
         chk(det_cyc - rise == 3, "R2 detect latency", det_cyc - rise, 3);
         chk(inj_cyc - det_cyc == 1, "R8 inject follows", inj_cyc - det_cyc, 1);
         chk(bit_period_o == exp_per, "R3 period", bit_period_o, exp_per);
      end else begin
         chk(det_n == d0, {req, " no detect"}, det_n - d0, 0);
         chk(bit_period_o == p0, "R9 period held", bit_period_o, p0);
      end
   endtask

   initial begin
      int olds[4];
      olds = '{48, 64, 96, 150};
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(!detect_o && !rx_restart_o && !inject_valid_o, "R1 strobes in reset",
          {detect_o, rx_restart_o, inject_valid_o}, 0);
      chk(inject_data_o == 8'h00, "R1 inject data", inject_data_o, 0);
      chk(bit_period_o == 0, "R1 period", bit_period_o, 0);
      rst_n = 1'b1;
      idle(100);
      chk(det_n == 0 && bit_period_o == 0, "R1 idle after reset", det_n, 0);

      // R3: exact ratios over a range of bit times
      for (int t = 2; t <= 41; t += 3) trial(6*t, t, 2*t, "R3");

      // R4: sweep middle run across the window edges
      for (int k = 0; k < 4; k++)
         for (int dm = -3; dm <= 3; dm++)
            trial(olds[k], olds[k]/6 + dm, olds[k]/3, "R4");

      // R5: sweep newest run across the window edges
      for (int k = 0; k < 4; k++)
         for (int dn = -3; dn <= 3; dn++)
            trial(olds[k], olds[k]/6, olds[k]/3 + dn, "R5");

      // R6: inverted pattern, runs ending high must not detect
      begin
         int d0;
         longint p0;
         d0 = det_n; p0 = bit_period_o;
         rx_async = 1'b0; repeat (30) @(negedge clk);
         rx_async = 1'b1; repeat (48) @(negedge clk);
         rx_async = 1'b0; repeat (8)  @(negedge clk);
         rx_async = 1'b1; repeat (16) @(negedge clk);
         rx_async = 1'b0; repeat (30) @(negedge clk);
         idle(200);
         chk(det_n == d0, "R6 high-ended pattern ignored", det_n - d0, 0);
         chk(bit_period_o == p0, "R6 period unchanged", bit_period_o, p0);
      end

      // R10: long low run saturates at CMAX instead of wrapping
      trial(300, 42, 85, "R10");

      chk(bad_rs == 0, "R7 restart equals detect", bad_rs, 0);
      chk(bad_dat == 0, "R8 inject data", bad_dat, 0);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #1500000;
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule